// File: doc/BRIEF.md
# Receive Buffer with Selectable Error Reporting

This block is the receive-side store of a serial port. The receiver hands it one character at a time: eight data bits plus three error flags (parity, framing, break). Each character is kept as one 11-bit word. The host pops characters with a read strobe. The host also watches a three-bit status output that reports errors in one of three ways. In character view, the status shows the flags of the character waiting at the head of the buffer. In block view, the status shows a sticky OR. A command picks whether that OR gathers flags as characters are written in, or as they are read out.

Block reporting lets the host test a whole burst once, rather than byte by byte. Gathering on entry raises the alarm while the faulty character is still queued. Gathering on exit ties the alarm to the data the host has already taken. The depth is normally 256 words. A reduced mode limits it to 8.

Top module: `rx_err_fifo`

## Requirements
- R1: While and after chip reset (`rst_n` low), `empty`=1, `full`=0, `stat`=0 and `rd_data`=0, and exit accumulation is selected.
- R2: Characters leave in the order they were written. `rd_data` takes the head byte on the clock edge that accepts `rd_en`. A read and a write in the same cycle both take effect.
- R3: With `small_mode`=0 the buffer holds 256 words. `full` is 1 exactly when all 256 are occupied, and `empty` is 1 exactly when none are.
- R4: With `small_mode`=1 the buffer holds 8 words, and `full` rises on the eighth stored word. `small_mode` is changed only while the buffer is empty.
- R5: A write while `full`=1 is dropped. The stored words and the count are unchanged.
- R6: A read while `empty`=1 leaves `rd_data` at its previous value and does not move the read position.
- R7: Status bit 0 is parity, bit 1 is framing and bit 2 is break. With `blk_mode`=0, `stat` equals the flags of the head word, or 0 when the buffer is empty.
- R8: In character view, the flags of a character stop showing once that character has been read, and the next head's flags replace them.
- R9: With entry accumulation selected (`sel_entry` pulse), the block latch ORs in the flags of every accepted write. With `blk_mode`=1 it shows on `stat` after the write's clock edge.
- R10: With exit accumulation selected (`sel_exit` pulse), the block latch ORs in the flags of each character as it is read out. Writes do not change the latch.
- R11: Switching `blk_mode` only changes which view is shown. It moves no pointer and alters no stored word.
- R12: An `err_rst` pulse clears the block latch and keeps the buffer contents.
- R13: An `rx_rst` pulse empties the buffer and clears the latch. It keeps the accumulation selection.
- R14: A clear on `err_rst` or `rx_rst` takes precedence over an accumulation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received byte |
| wr_stat | input | 3 | Flags of received byte: {break, framing, parity} |
| rd_en | input | 1 | Host read strobe |
| blk_mode | input | 1 | 0 character view, 1 block view |
| sel_entry | input | 1 | Pulse: accumulate on entry (wins over sel_exit) |
| sel_exit | input | 1 | Pulse: accumulate on exit |
| err_rst | input | 1 | Pulse: clear block latch |
| rx_rst | input | 1 | Pulse: empty buffer and clear latch |
| small_mode | input | 1 | 1 selects 8-word depth |
| rd_data | output | 8 | Last byte read |
| stat | output | 3 | Error status for the selected view |
| full | output | 1 | All positions occupied |
| empty | output | 1 | No position occupied |

## Verification
Every strobe takes effect on the rising edge after it is driven. `full`, `empty`, `rd_data` and the block latch show the new value right after that edge. The character-view status follows the new head within the same edge, because the head word is read combinationally. The choice of view on `blk_mode` reaches `stat` without any register. The bench therefore drives inputs on a falling edge and samples on the next falling edge, one rising edge later, while `blk_mode` is still held. This places every expected value one register stage after its stimulus.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
    localparam int ST_W = 3;

    typedef enum logic {
        ACC_EXIT  = 1'b0,
        ACC_ENTRY = 1'b1
    } acc_sel_e;
endpackage

// File: rtl/rx_fifo_ptrs.sv
module rx_fifo_ptrs #(
    parameter int DEPTH_MAX = 256,
    parameter int DEPTH_MIN = 8,
    localparam int AW = $clog2(DEPTH_MAX),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_rst,
    input  logic          small_mode,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] LIM_MAX = CW'(DEPTH_MAX);
    localparam logic [CW-1:0] LIM_MIN = CW'(DEPTH_MIN);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_st_t;

    ptr_st_t       st_d, st_q;
    logic [CW-1:0] lim;
    logic [AW-1:0] last;

    always_comb begin
        lim   = small_mode ? LIM_MIN : LIM_MAX;
        last  = AW'(lim - CW'(1));
        full  = (st_q.cnt == lim);
        empty = (st_q.cnt == '0);
        wr_ok = wr_en && !full && !rx_rst;
        rd_ok = rd_en && !empty && !rx_rst;
        st_d  = st_q;
        if (rx_rst) begin
            st_d = '0;
        end else begin
            if (wr_ok) st_d.wp = (st_q.wp == last) ? '0 : st_q.wp + 1'b1;
            if (rd_ok) st_d.rp = (st_q.rp == last) ? '0 : st_q.rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr = st_q.wp;
    assign raddr = st_q.rp;
endmodule

// File: rtl/rx_fifo_mem.sv
module rx_fifo_mem #(
    parameter int WORD_W = 11,
    parameter int DEPTH  = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Storage carries no reset: the status path masks the head when empty.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wword;
    end

    assign rword = mem_q[raddr];
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
    import rx_fifo_pkg::*;
#(
    parameter int SW = ST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_rst,
    input  logic          rx_rst,
    input  logic          sel_entry,
    input  logic          sel_exit,
    input  logic          blk_mode,
    input  logic          wr_ok,
    input  logic [SW-1:0] wr_stat,
    input  logic          rd_ok,
    input  logic [SW-1:0] head_stat,
    input  logic          empty,
    output logic [SW-1:0] stat,
    output acc_sel_e      acc_sel
);
    typedef struct packed {
        acc_sel_e      sel;
        logic [SW-1:0] lat;
    } err_st_t;

    err_st_t       st_d, st_q;
    logic [SW-1:0] feed;

    always_comb begin
        st_d = st_q;
        if (sel_entry)     st_d.sel = ACC_ENTRY;
        else if (sel_exit) st_d.sel = ACC_EXIT;

        feed = '0;
        if (st_q.sel == ACC_ENTRY && wr_ok) feed = wr_stat;
        if (st_q.sel == ACC_EXIT && rd_ok)  feed = head_stat;

        // a clear beats a same-cycle accumulation
        if (err_rst || rx_rst) st_d.lat = '0;
        else                   st_d.lat = st_q.lat | feed;

        stat    = blk_mode ? st_q.lat : (empty ? '0 : head_stat);
        acc_sel = st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: ACC_EXIT, lat: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH_MAX = 256,
    parameter int DEPTH_MIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ST_W-1:0]   wr_stat,
    input  logic              rd_en,
    input  logic              blk_mode,
    input  logic              sel_entry,
    input  logic              sel_exit,
    input  logic              err_rst,
    input  logic              rx_rst,
    input  logic              small_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic [ST_W-1:0]   stat,
    output logic              full,
    output logic              empty
);
    localparam int WORD_W = DATA_W + ST_W;
    localparam int AW     = $clog2(DEPTH_MAX);

    logic              wr_ok, rd_ok;
    logic [AW-1:0]     waddr, raddr;
    logic [WORD_W-1:0] head_word;
    acc_sel_e          acc_sel;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } top_st_t;

    top_st_t st_d, st_q;

    rx_fifo_ptrs #(
        .DEPTH_MAX (DEPTH_MAX),
        .DEPTH_MIN (DEPTH_MIN)
    ) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rst     (rx_rst),
        .small_mode (small_mode),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wr_ok      (wr_ok),
        .rd_ok      (rd_ok),
        .waddr      (waddr),
        .raddr      (raddr),
        .full       (full),
        .empty      (empty)
    );

    rx_fifo_mem #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH_MAX)
    ) u_mem (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (waddr),
        .wword ({wr_stat, wr_data}),
        .raddr (raddr),
        .rword (head_word)
    );

    rx_err_status #(
        .SW (ST_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_rst   (err_rst),
        .rx_rst    (rx_rst),
        .sel_entry (sel_entry),
        .sel_exit  (sel_exit),
        .blk_mode  (blk_mode),
        .wr_ok     (wr_ok),
        .wr_stat   (wr_stat),
        .rd_ok     (rd_ok),
        .head_stat (head_word[WORD_W-1:DATA_W]),
        .empty     (empty),
        .stat      (stat),
        .acc_sel   (acc_sel)
    );

    always_comb begin
        st_d = st_q;
        if (rd_ok) st_d.rd = head_word[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk
    import rx_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ST_W-1:0]   wr_stat,
    input logic              rd_en,
    input logic              blk_mode,
    input logic              err_rst,
    input logic              rx_rst,
    input logic [DATA_W-1:0] rd_data,
    input logic [ST_W-1:0]   stat,
    input logic              full,
    input logic              empty,
    input acc_sel_e          acc_sel
);
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_rxrst_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (empty && !full));

    assert_full_drops_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !rx_rst) |=> (full && $stable(rd_data)));

    assert_empty_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !rx_rst) |=> (empty && $stable(rd_data)));

    assert_clear_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rst || rx_rst) |=> (!blk_mode || stat == '0));

    assert_block_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && !err_rst && !rx_rst) ##1 blk_mode
        |-> ((stat & $past(stat)) == $past(stat)));

    assert_entry_gathers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && acc_sel == ACC_ENTRY && wr_en && !full && !err_rst && !rx_rst)
        ##1 blk_mode |-> ((stat & $past(wr_stat)) == $past(wr_stat)));

    assert_char_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && empty) |-> (stat == '0));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_stat  (wr_stat),
    .rd_en    (rd_en),
    .blk_mode (blk_mode),
    .err_rst  (err_rst),
    .rx_rst   (rx_rst),
    .rd_data  (rd_data),
    .stat     (stat),
    .full     (full),
    .empty    (empty),
    .acc_sel  (acc_sel)
);

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic       we;
        logic [7:0] wd;
        logic [2:0] ws;
        logic       re;
        logic       bm;
        logic       e_empty;
        logic       e_full;
        logic [2:0] e_stat;
        logic       ck;
        logic [7:0] e_rd;
    } vec_t;

    // R2 R7 R8 R10 R11 R6 across the walk (exit accumulation, 256 depth)
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00},
        '{1'b1, 8'hB2, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00},
        '{1'b1, 8'hC3, 3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 8'h00},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010, 1'b1, 8'hA1},
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'hA1},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 3'b010, 1'b1, 8'hB2},
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 8'hB2},
        '{1'b1, 8'hD4, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 8'hC3},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1, 8'hD4},
        '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 8'hD4},
        '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 8'hD4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, blk_mode = 1'b0;
    logic       sel_entry = 1'b0, sel_exit = 1'b0, err_rst = 1'b0, rx_rst = 1'b0;
    logic       small_mode = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_stat = '0;
    logic [7:0] rd_data;
    logic [2:0] stat;
    logic       full, empty;

    int n_chk = 0;
    int n_err = 0;

    rx_err_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_stat(wr_stat), .rd_en(rd_en), .blk_mode(blk_mode),
        .sel_entry(sel_entry), .sel_exit(sel_exit), .err_rst(err_rst),
        .rx_rst(rx_rst), .small_mode(small_mode), .rd_data(rd_data),
        .stat(stat), .full(full), .empty(empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [2:0] s);
        wr_en = 1'b1; wr_data = d; wr_stat = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_err();  err_rst = 1'b1;  @(negedge clk); err_rst = 1'b0;  endtask
    task automatic pulse_rx();   rx_rst = 1'b1;   @(negedge clk); rx_rst = 1'b0;   endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual hung expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 empty in reset", empty, 1);
        chk("R1 full in reset", full, 0);
        chk("R1 stat in reset", stat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty after reset", empty, 1);
        chk("R1 rd_data after reset", rd_data, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr_en = TBL[i].we; wr_data = TBL[i].wd; wr_stat = TBL[i].ws;
            rd_en = TBL[i].re; blk_mode = TBL[i].bm;
            @(negedge clk);
            chk($sformatf("R2/R7 vec %0d empty", i), empty, TBL[i].e_empty);
            chk($sformatf("R3 vec %0d full", i), full, TBL[i].e_full);
            chk($sformatf("R7/R8/R10/R11 vec %0d stat", i), stat, TBL[i].e_stat);
            if (TBL[i].ck) chk($sformatf("R2/R6 vec %0d rd_data", i), rd_data, TBL[i].e_rd);
            wr_en = 1'b0; rd_en = 1'b0;
        end

        // R12 and R10: exit latch holds 111; a write must not change it
        blk_mode = 1'b1;
        wr(8'hE5, 3'b100);
        chk("R10 write leaves exit latch", stat, 3'b111);
        pulse_err();
        chk("R12 err_rst clears latch", stat, 3'b000);
        chk("R12 contents kept", empty, 0);
        rd();
        chk("R12 kept byte", rd_data, 8'hE5);
        chk("R10 read ORs flags", stat, 3'b100);

        // R9 entry accumulation, R14 clear priority
        sel_entry = 1'b1; @(negedge clk); sel_entry = 1'b0;
        pulse_rx();
        chk("R13 latch cleared", stat, 3'b000);
        wr(8'h11, 3'b000);
        chk("R9 clean write", stat, 3'b000);
        wr(8'h22, 3'b001);
        chk("R9 entry sets on write", stat, 3'b001);
        err_rst = 1'b1;
        wr(8'h33, 3'b010);
        err_rst = 1'b0;
        chk("R14 clear beats accumulate", stat, 3'b000);
        chk("R14 write still stored", empty, 0);
        wr(8'h44, 3'b100);
        chk("R9 accumulate after clear", stat, 3'b100);

        // R13 receiver reset
        pulse_rx();
        chk("R13 empty after rx_rst", empty, 1);
        chk("R13 latch cleared", stat, 3'b000);
        wr(8'h55, 3'b010);
        chk("R13 entry selection kept", stat, 3'b010);
        pulse_rx();
        sel_exit = 1'b1; @(negedge clk); sel_exit = 1'b0;

        // R3 R5 full depth, R7 head flags, R2 order
        blk_mode = 1'b0;
        for (int i = 0; i < 256; i++) begin
            wr(8'(i), 3'(i));
            if (i == 254) chk("R3 not full at 255", full, 0);
        end
        chk("R3 full at 256", full, 1);
        wr(8'hEE, 3'b111);
        chk("R5 still full", full, 1);
        for (int i = 0; i < 256; i++) begin
            if (stat !== 3'(i)) chk("R7 head flags", stat, 3'(i));
            rd();
            if (rd_data !== 8'(i)) chk("R2 order", rd_data, 8'(i));
        end
        n_chk += 2;
        chk("R5 dropped write not stored", empty, 1);
        rd();
        chk("R6 empty read holds", rd_data, 8'hFF);

        // R4 small depth
        pulse_rx();
        small_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wr(8'h80 + 8'(i), 3'b000);
            if (i == 6) chk("R4 not full at 7", full, 0);
        end
        chk("R4 full at 8", full, 1);
        wr(8'hEE, 3'b000);
        for (int i = 0; i < 8; i++) begin
            rd();
            chk("R4 small order", rd_data, 8'h80 + 8'(i));
        end
        chk("R4 R5 empty after 8", empty, 1);

        finish_run();
    end
endmodule